// File: doc/BRIEF.md
# Four-Bank Interleaved Word Memory Controller

This block spreads single-word reads and writes over four independent memory banks so that a run of requests to consecutive word addresses overlaps the banks' cycle times. The two low word-address bits pick the bank and the remaining bits pick the word inside it. Each bank delivers read data a fixed number of clocks after it starts an access, but it cannot take another access until its longer cycle time has passed. The controller keeps a separate busy countdown for every bank and holds off any request whose target bank is still busy.

Requests enter on a valid/ready channel one word wide. `req_ready` reflects the bank chosen by the address currently on `req_addr`. While `req_valid` is high and `req_ready` is low, the requester keeps `req_write`, `req_addr` and `req_wdata` unchanged. A transfer happens in a cycle where both are high. Requests are issued strictly in arrival order. Writes finish when they are accepted and produce no response. Read data comes back in request order on `rsp_valid`/`rsp_data`. This response channel has no back-pressure, so the requester must take each word in the cycle it is shown. A small in-order FIFO of bank numbers picks which bank supplies each response.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: After reset no bank is busy: `req_ready` is high for every address and `rsp_valid` is low.
- R2: Word address bits [1:0] select the bank and bits [ADDR_W-1:2] select the word inside that bank. Two addresses with equal low bits contend for one bank. Words at different in-bank addresses keep separate values.
- R3: Requests to four distinct banks, all idle, are accepted on four consecutive cycles.
- R4: Suppose an access to a bank is accepted in cycle c. A later request to that same bank has `req_ready` low until cycle c+CYC_T and is accepted no earlier than c+CYC_T. This holds for reads and for writes.
- R5: A read accepted in cycle c shows `rsp_valid` high with its data in cycle c+ACC_T.
- R6: Each accepted read yields exactly one response. Responses appear in acceptance order and accepted writes yield none.
- R7: A write updates the addressed word when it is accepted. Any later read of that word returns the written value.
- R8: A request to an idle bank is accepted even while other banks are busy, in the cycle right after the previous acceptance.
- R9: Requests never overtake each other. The request held while the channel is stalled is the next one issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Target bank of `req_addr` can start an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle per read |
| rsp_data | output | DATA_W | Read data |

## Verification
The bench builds the controller with ACC_T=3, CYC_T=5, a six-bit word address and sixteen-bit data. Because the cycle time is longer than the four-bank rotation, the fifth request of a sequential stream comes back to bank 0 before that bank is free. This exposes the one-cycle stall that a four-cycle cycle time would hide. An access time of three keeps three reads in flight, so the tag FIFO runs at full occupancy with a push and a pop in the same cycle. With sixteen words per bank, the in-bank address decode is exercised on distinct rows of every bank.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int BANKS  = 4;
  localparam int BANK_W = 2;
  typedef logic [BANK_W-1:0] bank_id_t;
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int ROW_W  = 6,
  parameter int DATA_W = 32,
  parameter int ACC_T  = 2,
  parameter int CYC_T  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              we,
  input  logic [ROW_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ROW_W;
  localparam int CNT_W = (CYC_T > 1) ? $clog2(CYC_T) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  cnt;
  logic [ACC_T-1:0]  pv;
  logic [DATA_W-1:0] pd [ACC_T];

  // busy countdown: loaded on every start, bank free again CYC_T cycles later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CNT_W'(CYC_T - 1);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end
  assign busy = (cnt != '0);

  always_ff @(posedge clk) begin
    if (start && we) mem[addr] <= wdata;
  end

  // access-time pipeline
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv <= '0;
    else begin
      pv[0] <= start && !we;
      for (int i = 1; i < ACC_T; i++) pv[i] <= pv[i-1];
    end
  end

  always_ff @(posedge clk) begin
    pd[0] <= mem[addr];
    for (int i = 1; i < ACC_T; i++) pd[i] <= pd[i-1];
  end

  assign rd_valid = pv[ACC_T-1];
  assign rd_data  = pd[ACC_T-1];

  // R4
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  generate
    if (CYC_T > 1) begin : g_occ
      // R4
      busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    end
  endgenerate
endmodule

// File: rtl/ilv_tag_fifo.sv
module ilv_tag_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[wp] <= din;
  end

  assign dout  = slots[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CNT_W'(DEPTH));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |-> pop);
  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl
  import ilv_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int ACC_T  = 2,
  parameter int CYC_T  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int ROW_W = ADDR_W - BANK_W;

  bank_id_t          sel;
  logic [ROW_W-1:0]  row;
  logic [BANKS-1:0]  bstart, bbusy, brvld;
  logic [DATA_W-1:0] brdat [BANKS];
  logic              fire;
  bank_id_t          head;
  logic              tag_empty, tag_full;

  assign sel       = req_addr[BANK_W-1:0];
  assign row       = req_addr[ADDR_W-1:BANK_W];
  assign req_ready = !bbusy[sel];
  assign fire      = req_valid && req_ready;

  always_comb begin
    bstart      = '0;
    bstart[sel] = fire;
  end

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      ilv_bank #(
        .ROW_W (ROW_W),
        .DATA_W(DATA_W),
        .ACC_T (ACC_T),
        .CYC_T (CYC_T)
      ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (bstart[b]),
        .we      (req_write),
        .addr    (row),
        .wdata   (req_wdata),
        .busy    (bbusy[b]),
        .rd_valid(brvld[b]),
        .rd_data (brdat[b])
      );
    end
  endgenerate

  ilv_tag_fifo #(
    .DEPTH(ACC_T),
    .W    (BANK_W)
  ) u_tags (
    .clk  (clk),
    .rst_n(rst_n),
    .push (fire && !req_write),
    .din  (sel),
    .pop  (rsp_valid),
    .dout (head),
    .empty(tag_empty),
    .full (tag_full)
  );

  assign rsp_valid = |brvld;
  assign rsp_data  = brdat[head];

  // R6
  one_bank_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(brvld));
  // R6
  rsp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!tag_empty && brvld[head]));
  // R6
  tag_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_write && tag_full) |-> rsp_valid);
endmodule

// File: tb/ilv_mem_ctrl_tb_top.sv
module ilv_mem_ctrl_tb_top;
  localparam int AW  = 6;
  localparam int DW  = 16;
  localparam int ACC = 3;
  localparam int CYC = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_data;

  always #5 clk = ~clk;

  ilv_mem_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ACC_T(ACC), .CYC_T(CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  int cyc = 0;
  int nchecks = 0, nerr = 0;
  bit done = 0;
  logic [DW-1:0] model [64];
  logic [DW-1:0] exp_d [256];
  int exp_c [256];
  logic [DW-1:0] got_d [256];
  int got_c [256];
  int nexp = 0, ngot = 0, nchk = 0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst_n && rsp_valid && ngot < 256) begin
      got_d[ngot] = rsp_data;
      got_c[ngot] = cyc;
      ngot++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int expv);
    nchecks++;
    if (act != expv) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic do_req(input logic wr, input int a, input logic [DW-1:0] d, output int acc);
    req_valid = 1'b1; req_write = wr; req_addr = a[AW-1:0]; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    acc = cyc;
    if (wr) model[a] = d;
    else begin
      exp_d[nexp] = model[a];
      exp_c[nexp] = cyc + ACC;
      nexp++;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (ACC + CYC + 2) @(negedge clk);
  endtask

  task automatic drain_check(input string req);
    int lim;
    settle();
    chk("R6", {req, " response count"}, ngot, nexp);
    lim = (ngot < nexp) ? ngot : nexp;
    for (int i = nchk; i < lim; i++) begin
      chk(req, "read data", int'(got_d[i]), int'(exp_d[i]));
      chk("R5", "response cycle", got_c[i], exp_c[i]);
    end
    nchk = nexp;
    ngot = nexp;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 4; a++) begin
      req_addr = AW'(a); #1;
      chk("R1", "ready after reset", int'(req_ready), 1);
    end
    chk("R1", "rsp_valid after reset", int'(rsp_valid), 0);
    @(negedge clk);
  endtask

  task automatic t_fill_readback();
    int t;
    for (int a = 0; a < 64; a++) do_req(1'b1, a, DW'(a * 123 + 7), t);
    settle();
    // R6: writes return nothing
    chk("R6", "no response to writes", ngot, 0);
    // R7 and R2: rows 0 and 1 of every bank read back distinct values
    for (int a = 0; a < 8; a++) do_req(1'b0, a, '0, t);
    drain_check("R7");
  endtask

  task automatic t_stream();
    int acc [4];
    for (int i = 0; i < 4; i++) do_req(1'b0, 8 + i, '0, acc[i]);
    for (int i = 1; i < 4; i++) chk("R3", "consecutive accept", acc[i] - acc[i-1], 1);
    drain_check("R5");
  endtask

  task automatic t_revisit();
    int a0, a1, a2, a3, t;
    do_req(1'b1, 12, 16'h5A5A, a0);
    do_req(1'b0, 16, '0, a1);
    chk("R4", "write then same bank", a1 - a0, CYC);
    do_req(1'b0, 20, '0, a2);
    chk("R4", "read then same bank", a2 - a1, CYC);
    settle();
    do_req(1'b1, 13, 16'hC3C3, a0);
    do_req(1'b0, 13, '0, a3);
    chk("R7", "read after write spacing", a3 - a0, CYC);
    drain_check("R7");
    t = 0;
  endtask

  task automatic t_fifth();
    int acc [5];
    for (int i = 0; i < 5; i++) do_req(1'b0, 28 + i, '0, acc[i]);
    for (int i = 1; i < 4; i++) chk("R3", "stream accept", acc[i] - acc[i-1], 1);
    // R9: fifth request (bank 0 again) held, then issued at the bank's cycle time
    chk("R9", "stalled fifth issue", acc[4] - acc[0], CYC);
    drain_check("R4");
  endtask

  task automatic t_other_bank();
    int a0, a1, a2, a3, a4;
    do_req(1'b1, 40, 16'h1234, a0);
    do_req(1'b0, 41, '0, a1);
    do_req(1'b0, 42, '0, a2);
    chk("R8", "idle bank 1 during busy bank 0", a1 - a0, 1);
    chk("R8", "idle bank 2 during busy banks", a2 - a1, 1);
    do_req(1'b0, 44, '0, a3);
    chk("R2", "low bits 00 contend", a3 - a0, CYC);
    do_req(1'b0, 45, '0, a4);
    chk("R2", "low bits 01 contend", a4 - a1, CYC);
    drain_check("R2");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_readback();
    t_stream();
    t_revisit();
    t_fifth();
    t_other_bank();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchecks++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  end
endmodule